// File: doc/BRIEF.md
# Floating-Point Instruction Queue Controller

This block sits between the integer pipeline and two floating-point execution pipes: an adder and a multiplier. The integer side offers at most one arithmetic operation and at most one non-arithmetic event per cycle. Arithmetic operations are written into a small in-order queue. Each entry carries the instruction word, its address, the target unit and the destination register. Events cover register and status loads and stores, queue stores, and integer multiply or divide. Events never occupy a queue slot.

Queued operations go to their unit in arrival order, one per cycle. An entry stays in the queue until its unit reports completion, so the head always retires first even when the two units differ in latency. The controller stalls the integer pipe in two cases: an operation arrives while the queue is full, or an event names a register that a queued or executing operation will still write. A fault reported at retirement does not trap the faulting operation. It is held, with its address, until the next floating-point request is accepted, and that request carries the report.

Top module: `fpq_ctrl`

## Requirements
- R1: After reset the queue is empty (qCount = 0), and stall, dispValid and excReport are all low.
- R2: An operation offered while stall is low and no exception is pending is written to the queue, and qCount rises by one. The queue holds at most 4 entries.
- R3: When opValid is high and the queue holds 4 entries, stall is high in that cycle and the offered operation is not written.
- R4: Entries are dispatched in arrival order, at most one per cycle. An entry is first offered on dispValid in the cycle after it was written. dispUnit is 0 for the adder and 1 for the multiplier.
- R5: The head entry leaves the queue only on a done pulse from the unit it was sent to. A done pulse from the other unit does not remove it.
- R6: An event with evUsesReg high stalls when evReg equals the destination of any entry in the queue. Any other event does not stall and does not change qCount.
- R7: An operation and a non-stalling event offered in the same cycle are both accepted.
- R8: An exception flag on the head's done pulse makes an exception pending and records the head's address on excAddr. No entry is dispatched while an exception is pending.
- R9: A pending exception is reported by excReport, in the same cycle, on the next accepted operation or event, and is then cleared. An operation that carries the report is not written to the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Arithmetic operation offered |
| opInstr | input | 32 | Operation instruction word |
| opAddr | input | 32 | Operation instruction address |
| opUnit | input | 1 | Target unit, 0 adder, 1 multiplier |
| opDst | input | 5 | Destination register of the operation |
| evValid | input | 1 | Non-arithmetic event offered |
| evUsesReg | input | 1 | Event depends on a floating-point register |
| evReg | input | 5 | Register the event depends on |
| stall | output | 1 | Hold the integer pipeline |
| dispValid | output | 1 | An entry is being sent to a unit |
| dispUnit | output | 1 | Unit of the dispatched entry |
| dispInstr | output | 32 | Instruction word of the dispatched entry |
| dispAddr | output | 32 | Address of the dispatched entry |
| addDone | input | 1 | Adder finished its oldest operation |
| addExc | input | 1 | That adder result raised an exception |
| mulDone | input | 1 | Multiplier finished its oldest operation |
| mulExc | input | 1 | That multiplier result raised an exception |
| excReport | output | 1 | Pending exception reported to the accepted request |
| excAddr | output | 32 | Address of the faulting operation |
| qCount | output | 3 | Entries currently held |

## Verification
The bench fills the queue to capacity and then offers one more operation. A design with an off-by-one in its full test would overwrite the head, which shows up as a wrong count. It sends a completion from the unit that does not own the head; a design that retired on any done would let the count fall early and break in-order completion. Events are checked against registers that are live, already retired and unrelated. A wrong liveness mask either stalls forever or lets a read pass a pending write. Finally, an exception arrives in the same cycle as a new operation. The bench checks that dispatch freezes, that the report appears on the next request and not on the faulting one, and that the reporting operation is not queued.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  parameter int QDEPTH  = 4;
  parameter int INSTR_W = 32;
  parameter int ADDR_W  = 32;
  parameter int REG_W   = 5;
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W  = $clog2(QDEPTH + 1);

  typedef enum logic {UNIT_ADD = 1'b0, UNIT_MUL = 1'b1} unit_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] dispPtr;
    logic [PTR_W-1:0] headPtr;
  } dpCmd_t;
endpackage

// File: rtl/fpq_datapath.sv
module fpq_datapath
  import fpq_pkg::*;
(
  input  logic               clk,
  input  dpCmd_t             cmd,
  input  logic [INSTR_W-1:0] wrInstr,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic               wrUnit,
  input  logic [REG_W-1:0]   wrDst,
  input  logic [REG_W-1:0]   cmpReg,
  output logic [INSTR_W-1:0] dispInstr,
  output logic [ADDR_W-1:0]  dispAddr,
  output logic               dispUnit,
  output logic               headUnit,
  output logic [ADDR_W-1:0]  headAddr,
  output logic [QDEPTH-1:0]  dstMatch
);
  logic [INSTR_W-1:0] instrMem [QDEPTH];
  logic [ADDR_W-1:0]  addrMem  [QDEPTH];
  logic               unitMem  [QDEPTH];
  logic [REG_W-1:0]   dstMem   [QDEPTH];

  always_ff @(posedge clk) begin
    if (cmd.wrEn) begin
      instrMem[cmd.wrPtr] <= wrInstr;
      addrMem[cmd.wrPtr]  <= wrAddr;
      unitMem[cmd.wrPtr]  <= wrUnit;
      dstMem[cmd.wrPtr]   <= wrDst;
    end
  end

  assign dispInstr = instrMem[cmd.dispPtr];
  assign dispAddr  = addrMem[cmd.dispPtr];
  assign dispUnit  = unitMem[cmd.dispPtr];
  assign headUnit  = unitMem[cmd.headPtr];
  assign headAddr  = addrMem[cmd.headPtr];

  for (genvar i = 0; i < QDEPTH; i++) begin : g_cmp
    assign dstMatch[i] = (dstMem[i] == cmpReg);
  end
endmodule

// File: rtl/fpq_control.sv
module fpq_control
  import fpq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              evValid,
  input  logic              evUsesReg,
  input  logic              addDone,
  input  logic              addExc,
  input  logic              mulDone,
  input  logic              mulExc,
  input  logic              headUnit,
  input  logic [ADDR_W-1:0] headAddr,
  input  logic [QDEPTH-1:0] dstMatch,
  output dpCmd_t            cmd,
  output logic              stall,
  output logic              dispValid,
  output logic              excReport,
  output logic [ADDR_W-1:0] excAddr,
  output logic [CNT_W-1:0]  qCount
);
  logic [CNT_W-1:0]  cnt, inFlight;
  logic [PTR_W-1:0]  headPtr;
  logic              excPend;
  logic [ADDR_W-1:0] excAddrQ;
  logic [QDEPTH-1:0] live;
  logic full, depHit, accept, enq, retire, headExcSel, newExc;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] p,
                                               input logic [CNT_W-1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= QDEPTH) s = s - QDEPTH;
    return PTR_W'(s);
  endfunction

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      int off;
      off = i - int'(headPtr);
      if (off < 0) off = off + QDEPTH;
      live[i] = (off < int'(cnt));
    end
  end

  assign full       = (cnt == CNT_W'(QDEPTH));
  assign depHit     = evValid && evUsesReg && |(live & dstMatch);
  assign stall      = (opValid && full) || depHit;
  assign accept     = (opValid || evValid) && !stall;
  assign excReport  = excPend && accept;
  assign enq        = opValid && !stall && !excPend;
  assign dispValid  = (cnt != inFlight) && !excPend;
  assign retire     = (inFlight != '0) && ((headUnit == UNIT_MUL) ? mulDone : addDone);
  assign headExcSel = (headUnit == UNIT_MUL) ? mulExc : addExc;
  assign newExc     = retire && headExcSel && (!excPend || excReport);

  assign cmd.wrEn    = enq;
  assign cmd.wrPtr   = wrapAdd(headPtr, cnt);
  assign cmd.dispPtr = wrapAdd(headPtr, inFlight);
  assign cmd.headPtr = headPtr;

  assign excAddr = excAddrQ;
  assign qCount  = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      inFlight <= '0;
      headPtr  <= '0;
      excPend  <= 1'b0;
      excAddrQ <= '0;
    end else begin
      cnt      <= cnt + CNT_W'(enq) - CNT_W'(retire);
      inFlight <= inFlight + CNT_W'(dispValid) - CNT_W'(retire);
      if (retire) headPtr <= wrapAdd(headPtr, CNT_W'(1));
      excPend  <= (excPend && !excReport) || newExc;
      if (newExc) excAddrQ <= headAddr;
    end
  end
endmodule

// File: rtl/fpq_ctrl.sv
module fpq_ctrl
  import fpq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [INSTR_W-1:0] opInstr,
  input  logic [ADDR_W-1:0]  opAddr,
  input  logic               opUnit,
  input  logic [REG_W-1:0]   opDst,
  input  logic               evValid,
  input  logic               evUsesReg,
  input  logic [REG_W-1:0]   evReg,
  output logic               stall,
  output logic               dispValid,
  output logic               dispUnit,
  output logic [INSTR_W-1:0] dispInstr,
  output logic [ADDR_W-1:0]  dispAddr,
  input  logic               addDone,
  input  logic               addExc,
  input  logic               mulDone,
  input  logic               mulExc,
  output logic               excReport,
  output logic [ADDR_W-1:0]  excAddr,
  output logic [CNT_W-1:0]   qCount
);
  dpCmd_t            cmd;
  logic              headUnit;
  logic [ADDR_W-1:0] headAddr;
  logic [QDEPTH-1:0] dstMatch;

  fpq_control u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .evValid(evValid),
    .evUsesReg(evUsesReg), .addDone(addDone), .addExc(addExc),
    .mulDone(mulDone), .mulExc(mulExc), .headUnit(headUnit),
    .headAddr(headAddr), .dstMatch(dstMatch), .cmd(cmd), .stall(stall),
    .dispValid(dispValid), .excReport(excReport), .excAddr(excAddr),
    .qCount(qCount)
  );

  fpq_datapath u_dp (
    .clk(clk), .cmd(cmd), .wrInstr(opInstr), .wrAddr(opAddr),
    .wrUnit(opUnit), .wrDst(opDst), .cmpReg(evReg),
    .dispInstr(dispInstr), .dispAddr(dispAddr), .dispUnit(dispUnit),
    .headUnit(headUnit), .headAddr(headAddr), .dstMatch(dstMatch)
  );
endmodule

// File: rtl/fpq_checker.sv
module fpq_checker
  import fpq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic             evValid,
  input logic             stall,
  input logic             dispValid,
  input logic             excReport,
  input logic [CNT_W-1:0] qCount
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(QDEPTH));

  a_r3_full_stall: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && qCount == CNT_W'(QDEPTH)) |-> stall);

  a_r2_no_growth_without_op: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> qCount <= $past(qCount));

  a_r4_dispatch_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> qCount != '0);

  a_r9_report_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    excReport |-> ((opValid || evValid) && !stall));
endmodule

bind fpq_ctrl fpq_checker u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .evValid(evValid),
  .stall(stall), .dispValid(dispValid), .excReport(excReport),
  .qCount(qCount)
);

// File: tb/tb_fpq_ctrl.sv
module tb_fpq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        unit;
    logic [4:0]  dst;
    logic [31:0] instr;
    logic [31:0] addr;
  } vec_t;

  // unit, destination, instruction word, address
  localparam vec_t VECS [4] = '{
    '{1'b0, 5'd1, 32'hF000_0000, 32'h0000_1000},
    '{1'b1, 5'd2, 32'hF000_0001, 32'h0000_1004},
    '{1'b1, 5'd3, 32'hF000_0002, 32'h0000_1008},
    '{1'b0, 5'd4, 32'hF000_0003, 32'h0000_100C}
  };

  logic clk = 0, rstN = 0;
  logic opValid = 0, opUnit = 0, evValid = 0, evUsesReg = 0;
  logic [31:0] opInstr = 0, opAddr = 0;
  logic [4:0] opDst = 0, evReg = 0;
  logic addDone = 0, addExc = 0, mulDone = 0, mulExc = 0;
  logic stall, dispValid, dispUnit, excReport;
  logic [31:0] dispInstr, dispAddr, excAddr;
  logic [2:0] qCount;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpq_ctrl dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opInstr(opInstr),
    .opAddr(opAddr), .opUnit(opUnit), .opDst(opDst), .evValid(evValid),
    .evUsesReg(evUsesReg), .evReg(evReg), .stall(stall),
    .dispValid(dispValid), .dispUnit(dispUnit), .dispInstr(dispInstr),
    .dispAddr(dispAddr), .addDone(addDone), .addExc(addExc),
    .mulDone(mulDone), .mulExc(mulExc), .excReport(excReport),
    .excAddr(excAddr), .qCount(qCount)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1;
    settle();
    check("R1 stall", stall, 0);
    check("R1 dispValid", dispValid, 0);
    check("R1 qCount", qCount, 0);
    check("R1 excReport", excReport, 0);

    // vector walk: fill queue, watch dispatch trail by one cycle
    for (int i = 0; i < 4; i++) begin
      tick();
      opValid = 1; opUnit = VECS[i].unit; opDst = VECS[i].dst;
      opInstr = VECS[i].instr; opAddr = VECS[i].addr;
      settle();
      check("R2 no stall while filling", stall, 0);
      if (i > 0) begin
        check("R4 dispValid", dispValid, 1);
        check("R4 dispInstr order", dispInstr, VECS[i-1].instr);
        check("R4 dispUnit", dispUnit, VECS[i-1].unit);
      end
    end
    tick();
    opValid = 0;
    settle();
    check("R4 last dispInstr", dispInstr, VECS[3].instr);
    check("R4 last dispAddr", dispAddr, VECS[3].addr);
    tick(); settle();
    check("R2 qCount full", qCount, 4);
    check("R4 nothing left to dispatch", dispValid, 0);

    // full queue
    opValid = 1; opInstr = 32'hDEAD_BEEF; opDst = 5'd20;
    settle();
    check("R3 stall on full", stall, 1);
    tick();
    opValid = 0;
    settle();
    check("R3 not written", qCount, 4);

    // wrong unit done, then in-order retirement
    mulDone = 1; tick(); mulDone = 0; settle();
    check("R5 other unit ignored", qCount, 4);
    addDone = 1; tick(); settle();
    check("R5 head retired", qCount, 3);
    tick(); addDone = 0; settle();
    check("R5 adder done cannot retire multiplier head", qCount, 3);

    // dependency on events
    evValid = 1; evUsesReg = 1; evReg = 5'd3;
    settle(); check("R6 live dst stalls", stall, 1);
    evReg = 5'd1;
    settle(); check("R6 retired dst no stall", stall, 0);
    evReg = 5'd9;
    settle(); check("R6 unrelated no stall", stall, 0);
    evUsesReg = 0; evReg = 5'd3;
    settle(); check("R6 no register use no stall", stall, 0);
    tick();
    evValid = 0;
    settle();
    check("R6 event not queued", qCount, 3);

    // op + event together while multiplier head faults
    opValid = 1; opUnit = 0; opDst = 5'd5; opInstr = 32'hF000_0004; opAddr = 32'h0000_1010;
    evValid = 1; evUsesReg = 1; evReg = 5'd9;
    mulDone = 1; mulExc = 1;
    settle();
    check("R7 both accepted", stall, 0);
    check("R9 no report without pending", excReport, 0);
    tick();
    opValid = 0; evValid = 0; mulDone = 0; mulExc = 0;
    settle();
    check("R7 count after op in and head out", qCount, 3);
    check("R8 dispatch frozen", dispValid, 0);
    check("R9 no report without request", excReport, 0);
    check("R8 excAddr captured", excAddr, 32'h0000_1004);
    tick(); settle();
    check("R8 still frozen", dispValid, 0);

    // report on next op
    opValid = 1; opUnit = 0; opDst = 5'd6; opInstr = 32'hF000_0005; opAddr = 32'h0000_1014;
    settle();
    check("R9 report", excReport, 1);
    tick();
    opValid = 0;
    settle();
    check("R9 reporting op not queued", qCount, 3);
    check("R9 cleared", excReport, 0);
    check("R8 dispatch resumes", dispValid, 1);
    check("R8 resumed entry", dispInstr, 32'hF000_0004);

    // drain
    tick();
    mulDone = 1; tick(); mulDone = 0;
    addDone = 1; tick(); tick(); addDone = 0;
    settle();
    check("R5 drained", qCount, 0);
    check("R5 drained no dispatch", dispValid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule